// File: doc/BRIEF.md
# Microframe Frame Index Counter

This block holds the running microframe number of a high-speed bus host controller. It is a 14-bit counter that steps once for each microframe tick, which arrives every 125 microseconds. The upper bits of the counter, above the three microframe bits, give the entry of the periodic schedule list that is current. The list can hold 1024, 512 or 256 entries, so the number of index bits that select an entry depends on a programmable size field.

Software may load a new counter value through a 32-bit register write port. The block accepts a load only while the controller reports itself halted, and only when all four byte enables are set. The loaded value is also the frame number that start-of-frame generation uses. A one-cycle wrap pulse marks each pass of the counter through the end of the list and feeds the interrupt logic.

Top module: `fi_index_counter`

## Requirements
- R1: After reset the register readback is 0 and the wrap pulse is low.
- R2: While run is 1, each cycle with the tick high and no accepted load raises the counter by one. The new value is visible on the clock edge that samples the tick.
- R3: While run is 0, ticks leave the counter unchanged.
- R4: A write with halted high and byte enables 4'b1111 loads write-data bits 13:0 into the counter. Readback bits 31:14 always read 0.
- R5: A write with any byte enable low is ignored and the counter keeps its value.
- R6: A write while halted is low is ignored and the counter keeps its value.
- R7: The entry output is counter bits (N:3), zero-extended to 10 bits. The size code 2'b00 gives N=12, 2'b01 gives N=11 and 2'b10 gives N=10. The code 2'b11 behaves like 2'b00.
- R8: The wrap pulse is high for exactly the one cycle in which an increment has just toggled counter bit N+1. A load never raises it.
- R9: The counter wraps from 14'h3FFF to 0.
- R10: When an accepted load and a tick with run high fall in the same cycle, the load wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | One-cycle pulse at each microframe boundary |
| run_en | input | 1 | Run/stop control; the counter advances only when this is 1 |
| halted | input | 1 | Controller halted indication; a load is allowed only when this is 1 |
| list_size | input | 2 | Frame list size code |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| reg_rdata | output | 32 | Register readback: counter in bits 13:0, zeros above |
| list_entry | output | 10 | Current list entry, zero-extended |
| wrap_pulse | output | 1 | One-cycle pulse when the counter passes the end of the list |

## Verification
Runs of ticks with run high and run low tell stepping apart from holding. Loads are tried with all byte enables set, with partial byte enables, with halted low, and in the same cycle as a tick, which shows the gate and the priority of a load over a tick. Every size code is swept with preset counter values next to the list boundary. This separates the three entry widths from one another and shows that a pulse comes at the bit N+1 toggle of each size but not after a load that lands on the same value. A load to 14'h3FFF followed by one tick checks the full wrap.

// File: rtl/fi_pkg.sv
package fi_pkg;
   typedef enum logic [1:0] {
      FL_1024 = 2'b00,
      FL_512  = 2'b01,
      FL_256  = 2'b10,
      FL_ALT  = 2'b11
   } fl_size_e;

   // number of index bits selecting a list entry for a size code
   function automatic int list_bits(input int code, input int max_bits);
      case (code)
         1:       return max_bits - 1;
         2:       return max_bits - 2;
         default: return max_bits;
      endcase
   endfunction
endpackage

// File: rtl/fi_wr_gate.sv
module fi_wr_gate #(
   parameter int REG_W = 32,
   parameter int IDX_W = 14
) (
   input  logic               wr_en,
   input  logic               halted,
   input  logic [REG_W/8-1:0] wr_be,
   input  logic [REG_W-1:0]   wr_data,
   output logic               load_o,
   output logic [IDX_W-1:0]   load_val_o
);
   localparam int BE_W = REG_W / 8;

   initial begin
      if (REG_W % 8 != 0) $error("REG_W must be a whole number of bytes");
      if (IDX_W > REG_W)  $error("IDX_W must fit in the register");
   end

   logic full_word;
   assign full_word  = (wr_be == {BE_W{1'b1}});
   assign load_o     = wr_en & halted & full_word;
   assign load_val_o = wr_data[IDX_W-1:0];
endmodule

// File: rtl/fi_counter.sv
module fi_counter #(
   parameter int IDX_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   output logic [IDX_W-1:0] idx_o,
   output logic             step_o
);
   initial begin
      if (IDX_W < 4) $error("IDX_W too small");
   end

   logic [IDX_W-1:0] idx_q;

   assign step_o = tick & run_en & ~load;

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (load)   idx_q <= load_val;
      else if (step_o) idx_q <= idx_q + 1'b1;
   end

   assign idx_o = idx_q;

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run_en && !load) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(tick && run_en)) |=> $stable(idx_q));
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (idx_q == $past(load_val)));
endmodule

// File: rtl/fi_entry_sel.sv
module fi_entry_sel
   import fi_pkg::*;
#(
   parameter int IDX_W     = 14,
   parameter int SUB_W     = 3,
   parameter int MAX_LBITS = 10
) (
   input  logic [IDX_W-1:0]     idx,
   input  logic [1:0]           size_code,
   output logic [MAX_LBITS-1:0] entry_o
);
   initial begin
      if (SUB_W + MAX_LBITS >= IDX_W) $error("index too narrow for list");
      if (MAX_LBITS < 3)              $error("MAX_LBITS too small");
   end

   logic [MAX_LBITS-1:0] cand [4];

   for (genvar g = 0; g < 4; g++) begin : g_size
      localparam int LB = list_bits(g, MAX_LBITS);
      if (LB == MAX_LBITS) begin : g_full
         assign cand[g] = idx[SUB_W +: MAX_LBITS];
      end else begin : g_part
         assign cand[g] = {{(MAX_LBITS-LB){1'b0}}, idx[SUB_W +: LB]};
      end
   end

   assign entry_o = cand[size_code];
endmodule

// File: rtl/fi_wrap_det.sv
module fi_wrap_det
   import fi_pkg::*;
#(
   parameter int IDX_W     = 14,
   parameter int SUB_W     = 3,
   parameter int MAX_LBITS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       size_code,
   input  logic             step,
   output logic             wrap_o
);
   localparam int TOP_MAX = SUB_W + MAX_LBITS;

   initial begin
      if (TOP_MAX >= IDX_W) $error("wrap bit falls outside index");
   end

   // mask of bits N:0 for the selected size; all ones below means the
   // next increment toggles bit N+1
   logic [IDX_W-1:0] low_mask;
   always_comb begin
      low_mask = '0;
      for (int b = 0; b < IDX_W; b++)
         if (b < SUB_W + list_bits(int'(size_code), MAX_LBITS)) low_mask[b] = 1'b1;
   end

   logic at_edge, wrap_q;
   assign at_edge = &(idx | ~low_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) wrap_q <= 1'b0;
      else        wrap_q <= step & at_edge;
   end

   assign wrap_o = wrap_q;

   a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |=> !wrap_q);
   a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> !wrap_q);
endmodule

// File: rtl/fi_index_counter.sv
module fi_index_counter #(
   parameter int REG_W     = 32,
   parameter int IDX_W     = 14,
   parameter int SUB_W     = 3,
   parameter int MAX_LBITS = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 uframe_tick,
   input  logic                 run_en,
   input  logic                 halted,
   input  logic [1:0]           list_size,
   input  logic                 wr_en,
   input  logic [REG_W/8-1:0]   wr_be,
   input  logic [REG_W-1:0]     wr_data,
   output logic [REG_W-1:0]     reg_rdata,
   output logic [MAX_LBITS-1:0] list_entry,
   output logic                 wrap_pulse
);
   localparam int PAD_W = REG_W - IDX_W;

   initial begin
      if (PAD_W < 1) $error("register must have reserved bits above index");
   end

   logic             load;
   logic [IDX_W-1:0] load_val, idx;
   logic             step;

   fi_wr_gate #(.REG_W(REG_W), .IDX_W(IDX_W)) u_gate (
      .wr_en(wr_en), .halted(halted), .wr_be(wr_be), .wr_data(wr_data),
      .load_o(load), .load_val_o(load_val));

   fi_counter #(.IDX_W(IDX_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(uframe_tick), .run_en(run_en),
      .load(load), .load_val(load_val), .idx_o(idx), .step_o(step));

   fi_entry_sel #(.IDX_W(IDX_W), .SUB_W(SUB_W), .MAX_LBITS(MAX_LBITS)) u_sel (
      .idx(idx), .size_code(list_size), .entry_o(list_entry));

   fi_wrap_det #(.IDX_W(IDX_W), .SUB_W(SUB_W), .MAX_LBITS(MAX_LBITS)) u_wrap (
      .clk(clk), .rst_n(rst_n), .idx(idx), .size_code(list_size),
      .step(step), .wrap_o(wrap_pulse));

   assign reg_rdata = {{PAD_W{1'b0}}, idx};

   a_r6_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted && !(uframe_tick && run_en)) |=> $stable(reg_rdata));
   a_r5_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_be != {(REG_W/8){1'b1}} && !(uframe_tick && run_en)) |=> $stable(reg_rdata));
endmodule

// File: tb/tb_fi_index_counter.sv
module tb_fi_index_counter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        uframe_tick = 1'b0, run_en = 1'b0, halted = 1'b1;
   logic [1:0]  list_size = 2'b00;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_be = 4'h0;
   logic [31:0] wr_data = '0;
   logic [31:0] reg_rdata;
   logic [9:0]  list_entry;
   logic        wrap_pulse;

   int n_run = 0, n_fail = 0;
   int m_idx = 0;
   bit m_wrap = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fi_index_counter dut (
      .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .run_en(run_en),
      .halted(halted), .list_size(list_size), .wr_en(wr_en), .wr_be(wr_be),
      .wr_data(wr_data), .reg_rdata(reg_rdata), .list_entry(list_entry),
      .wrap_pulse(wrap_pulse));

   function automatic int lbits(input logic [1:0] c);
      return (c == 2'b01) ? 9 : (c == 2'b10) ? 8 : 10;
   endfunction

   task automatic chk(input string tag, input int act, input int exp, input string what);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      int lb;
      lb = lbits(list_size);
      chk(tag, int'(reg_rdata), m_idx, "rdata");
      chk(tag, int'(list_entry), (m_idx >> 3) & ((1 << lb) - 1), "entry");
      chk(tag, int'(wrap_pulse), int'(m_wrap), "wrap");
   endtask

   // one clock: model update from current inputs, then compare after edge
   task automatic step(input string tag);
      bit ld, inc;
      int lb, lowm;
      ld   = wr_en && halted && (wr_be == 4'hF);
      inc  = uframe_tick && run_en && !ld;
      lb   = lbits(list_size);
      lowm = (1 << (lb + 3)) - 1;
      m_wrap = inc && ((m_idx & lowm) == lowm);
      if (ld)       m_idx = int'(wr_data) & 16'h3FFF;
      else if (inc) m_idx = (m_idx + 1) & 16'h3FFF;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic tick_n(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         uframe_tick = 1'b1; step(tag);
         uframe_tick = 1'b0; step(tag);
      end
   endtask

   task automatic wr(input logic [31:0] d, input logic [3:0] be, input string tag);
      wr_en = 1'b1; wr_data = d; wr_be = be;
      step(tag);
      wr_en = 1'b0; wr_be = 4'h0;
      step(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1");
      step("R1");

      // R4: full load while halted, reserved bits must read 0
      wr(32'hFFFF_C5A8, 4'hF, "R4");
      wr(32'h0000_0123, 4'hF, "R4");
      // R5: partial byte enables
      wr(32'h0000_0777, 4'h7, "R5");
      wr(32'h0000_0777, 4'h1, "R5");
      // R3: ticks with run low
      tick_n(4, "R3");
      // R2: run and step
      halted = 1'b0; run_en = 1'b1;
      tick_n(10, "R2");
      uframe_tick = 1'b1; step("R2"); step("R2"); step("R2");
      uframe_tick = 1'b0; step("R2");
      // R6: write while running is dropped
      wr(32'h0000_3000, 4'hF, "R6");
      tick_n(2, "R6");
      run_en = 1'b0; halted = 1'b1;
      tick_n(2, "R3");

      // R7/R8: each size code near its boundary
      for (int c = 0; c < 4; c++) begin
         list_size = 2'(c);
         compare("R7");
         wr(32'h0000_1FFD, 4'hF, "R7");
         wr(32'h0000_07FD, 4'hF, "R7");
         wr(32'h0000_0FFE, 4'hF, "R8");
         halted = 1'b0; run_en = 1'b1;
         tick_n(4, "R8");
         run_en = 1'b0; halted = 1'b1;
         wr(32'h0000_07FE, 4'hF, "R8");
         halted = 1'b0; run_en = 1'b1;
         tick_n(4, "R8");
         run_en = 1'b0; halted = 1'b1;
         wr(32'h0000_1FFE, 4'hF, "R8");
         halted = 1'b0; run_en = 1'b1;
         tick_n(4, "R8");
         run_en = 1'b0; halted = 1'b1;
         // a load landing on the boundary gives no pulse
         wr(32'h0000_2000, 4'hF, "R8");
      end

      // R9: full wrap
      list_size = 2'b00;
      wr(32'h0000_3FFE, 4'hF, "R9");
      run_en = 1'b1;
      tick_n(3, "R9");

      // R10: load and tick in the same cycle
      halted = 1'b1; run_en = 1'b1;
      uframe_tick = 1'b1; wr_en = 1'b1; wr_be = 4'hF; wr_data = 32'h0000_0555;
      step("R10");
      uframe_tick = 1'b0; wr_en = 1'b0; wr_be = 4'h0;
      step("R10");
      run_en = 1'b0;

      // R1: reset again clears state
      rst_n = 1'b0;
      m_idx = 0; m_wrap = 0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      compare("R1");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule